// File: doc/BRIEF.md
# Descriptor-Ring DMA Engine

This engine moves blocks of 32-bit words between a word-addressed memory port and a device. It takes its work from a circular array of descriptors held in that same memory, so software never programs a transfer register by register. Software lays the ring out at a base address, gives its number of entries, fills in descriptors and marks them valid, then pulses a doorbell. The engine reads the descriptor at its current ring position and, if the descriptor is valid, carries out the transfer it describes. When the transfer ends, the engine writes the descriptor's flag word back as done and moves to the next ring position, wrapping at the end of the ring. It fetches the next descriptor straight away. When it meets a descriptor that is not valid, it stops and waits for the next doorbell.

Each descriptor is four consecutive words at `base + 4*index`. The first word is the buffer word address. The second is the length in words. The third is control: bit 0 gives the direction and bits 31:8 carry a device parameter. The fourth holds flags: bit 0 means valid (owned by hardware) and bit 1 means done. Direction 0 reads the buffer and streams it out on `dev_tx_*`. Direction 1 takes words from `dev_rx_*` and writes them into the buffer.

The memory request channel and both device streams use valid/ready handshakes. A word moves only in a cycle where valid and ready are both high. A sender that raises valid keeps valid, address and data unchanged until ready is seen, so back-pressure on any of the three channels stalls the engine without losing a word. The engine keeps one memory request outstanding at a time. A read response arrives on `mem_rsp_valid` some cycles after the read is accepted, and the engine always takes it. The interrupt is a one-cycle pulse whose policy is set by `cfg_irq_mode`.

Top module: `dma_ring_engine`

## Requirements
- R1: After reset the engine is idle: `busy` and `irq` are low, `cur_index` is 0 and `mem_req_valid` is low.
- R2: A descriptor is fetched as four word reads at `cfg_base + 4*cur_index + k` for k = 0..3. Word 0 is the buffer address, word 1 the length, word 2 control (bit 0 direction, bits 31:8 device parameter), word 3 flags (bit 0 valid, bit 1 done). During the transfer, `dev_param` shows control bits 31:8 and `dev_dir` shows bit 0.
- R3: With direction 0, the words at buffer address, buffer address + 1, and onward up to the length are read in order and presented on `dev_tx_data`. Each word stays stable while `dev_tx_valid` is high and `dev_tx_ready` is low.
- R4: With direction 1, each word accepted on the `dev_rx_*` stream is written to the next consecutive buffer address, starting at the buffer address, for the given number of words.
- R5: After the last data word, the engine writes the value 32'h2 (done set, valid clear) to the descriptor's flag word.
- R6: After each write-back, `cur_index` moves to the next ring position and returns to 0 after position `cfg_count`-1.
- R7: After a write-back, the engine fetches the next descriptor without a doorbell, so a chain of valid descriptors runs from one doorbell.
- R8: When a fetched descriptor's valid bit is 0, the engine goes idle, writes nothing, and issues no memory request until `doorbell` is pulsed.
- R9: A valid descriptor with length 0 is written back as done with no data moved.
- R10: With `cfg_irq_mode` = 0, `irq` pulses high for exactly one cycle after each descriptor's write-back.
- R11: With `cfg_irq_mode` = 1, `irq` pulses once when an invalid descriptor is found after at least one descriptor has completed since the engine last went idle. It does not pulse when no descriptor completed.
- R12: While `mem_req_valid` is high and `mem_req_ready` is low, the request valid, address, write flag and write data stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_base | input | ADDR_W | Word address of ring entry 0 |
| cfg_count | input | RING_W+1 | Number of ring entries |
| cfg_irq_mode | input | 1 | 0: interrupt per request, 1: interrupt when ring runs dry |
| doorbell | input | 1 | One-cycle pulse asking the engine to poll the ring |
| cur_index | output | RING_W | Current ring position |
| busy | output | 1 | Engine is not idle |
| irq | output | 1 | One-cycle interrupt pulse |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory request accepted |
| mem_req_write | output | 1 | 1 write, 0 read |
| mem_req_addr | output | ADDR_W | Word address |
| mem_req_wdata | output | 32 | Write data |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_rdata | input | 32 | Read data |
| dev_tx_valid | output | 1 | Word to device valid |
| dev_tx_ready | input | 1 | Device takes the word |
| dev_tx_data | output | 32 | Word to device |
| dev_rx_valid | input | 1 | Word from device valid |
| dev_rx_ready | output | 1 | Engine takes the word |
| dev_rx_data | input | 32 | Word from device |
| dev_param | output | 24 | Device parameter of the current descriptor |
| dev_dir | output | 1 | Direction of the current descriptor |

## Verification
A wrong ring position shows up on `cur_index` once a write-back completes, and on the flag word address of the next fetch. A wrong position therefore makes the bench see an untouched flag word at the descriptor it expected done, within one descriptor's run. A lost length or offset count appears as too many or too few words on the device stream, or in the buffer, before the engine next goes idle. A stuck doorbell latch or a faulty idle decision shows up as memory requests during a quiet window, which the bench counts directly. A wrong interrupt policy state appears as the wrong pulse count, measured two cycles after the engine settles.

// File: rtl/dma_ring_pkg.sv
package dma_ring_pkg;
  localparam int WORD_W    = 32;
  localparam int DESC_SPAN = 4;
  localparam int PARAM_W   = 24;
  localparam logic [WORD_W-1:0] FLAGS_DONE = 32'h0000_0002;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_FETCH_REQ,
    ST_FETCH_WAIT,
    ST_CHECK,
    ST_RD_REQ,
    ST_RD_WAIT,
    ST_TX,
    ST_RX,
    ST_WR_REQ,
    ST_WB_REQ
  } eng_state_t;
endpackage

// File: rtl/dma_ring_index.sv
module dma_ring_index #(
  parameter int RING_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              advance,
  input  logic [RING_W:0]   cfg_count,
  output logic [RING_W-1:0] idx
);
  logic [RING_W:0] nxt;

  assign nxt = {1'b0, idx} + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx <= '0;
    end else if (advance) begin
      if (nxt >= cfg_count) idx <= '0;
      else                  idx <= nxt[RING_W-1:0];
    end
  end
endmodule

// File: rtl/dma_ring_irq.sv
module dma_ring_irq (
  input  logic clk,
  input  logic rst_n,
  input  logic mode_dry,
  input  logic desc_done,
  input  logic ring_dry,
  output logic irq
);
  logic served;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      served <= 1'b0;
      irq    <= 1'b0;
    end else begin
      if (desc_done)     served <= 1'b1;
      else if (ring_dry) served <= 1'b0;
      if (mode_dry) irq <= ring_dry & served;
      else          irq <= desc_done;
    end
  end
endmodule

// File: rtl/dma_ring_ctrl.sv
module dma_ring_ctrl
  import dma_ring_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int RING_W = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ADDR_W-1:0]  cfg_base,
  input  logic               doorbell,
  input  logic [RING_W-1:0]  idx,
  output logic               busy,
  output logic               desc_done,
  output logic               ring_dry,
  output logic               mem_req_valid,
  input  logic               mem_req_ready,
  output logic               mem_req_write,
  output logic [ADDR_W-1:0]  mem_req_addr,
  output logic [WORD_W-1:0]  mem_req_wdata,
  input  logic               mem_rsp_valid,
  input  logic [WORD_W-1:0]  mem_rsp_rdata,
  output logic               dev_tx_valid,
  input  logic               dev_tx_ready,
  output logic [WORD_W-1:0]  dev_tx_data,
  input  logic               dev_rx_valid,
  output logic               dev_rx_ready,
  input  logic [WORD_W-1:0]  dev_rx_data,
  output logic [PARAM_W-1:0] dev_param,
  output logic               dev_dir
);
  localparam int PAD_W = ADDR_W - RING_W - 2;

  eng_state_t          state;
  logic                kick;
  logic [1:0]          word_k;
  logic [ADDR_W-1:0]   desc_buf;
  logic [WORD_W-1:0]   desc_len;
  logic [PARAM_W-1:0]  desc_param;
  logic                desc_dir;
  logic                desc_valid;
  logic [ADDR_W-1:0]   offs;
  logic [WORD_W-1:0]   remain;
  logic [WORD_W-1:0]   hold;
  logic [ADDR_W-1:0]   desc_base;
  logic                last_word;

  assign desc_base = cfg_base + {{PAD_W{1'b0}}, idx, 2'b00};
  assign last_word = (remain == 32'd1);

  always_comb begin
    mem_req_valid = 1'b0;
    mem_req_write = 1'b0;
    mem_req_addr  = desc_base;
    mem_req_wdata = hold;
    unique case (state)
      ST_FETCH_REQ: begin
        mem_req_valid = 1'b1;
        mem_req_addr  = desc_base + {{(ADDR_W-2){1'b0}}, word_k};
      end
      ST_RD_REQ: begin
        mem_req_valid = 1'b1;
        mem_req_addr  = desc_buf + offs;
      end
      ST_WR_REQ: begin
        mem_req_valid = 1'b1;
        mem_req_write = 1'b1;
        mem_req_addr  = desc_buf + offs;
      end
      ST_WB_REQ: begin
        mem_req_valid = 1'b1;
        mem_req_write = 1'b1;
        mem_req_addr  = desc_base + ADDR_W'(DESC_SPAN - 1);
        mem_req_wdata = FLAGS_DONE;
      end
      default: ;
    endcase
  end

  assign dev_tx_valid = (state == ST_TX);
  assign dev_tx_data  = hold;
  assign dev_rx_ready = (state == ST_RX);
  assign dev_param    = desc_param;
  assign dev_dir      = desc_dir;
  assign busy         = (state != ST_IDLE);
  assign desc_done    = (state == ST_WB_REQ) && mem_req_ready;
  assign ring_dry     = (state == ST_CHECK) && !desc_valid;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      kick       <= 1'b0;
      word_k     <= '0;
      desc_buf   <= '0;
      desc_len   <= '0;
      desc_param <= '0;
      desc_dir   <= 1'b0;
      desc_valid <= 1'b0;
      offs       <= '0;
      remain     <= '0;
      hold       <= '0;
    end else begin
      if (doorbell)                         kick <= 1'b1;
      else if (state == ST_IDLE && kick)    kick <= 1'b0;

      unique case (state)
        ST_IDLE: begin
          if (kick) begin
            word_k <= '0;
            state  <= ST_FETCH_REQ;
          end
        end
        ST_FETCH_REQ: if (mem_req_ready) state <= ST_FETCH_WAIT;
        ST_FETCH_WAIT: begin
          if (mem_rsp_valid) begin
            unique case (word_k)
              2'd0: desc_buf <= mem_rsp_rdata[ADDR_W-1:0];
              2'd1: desc_len <= mem_rsp_rdata;
              2'd2: begin
                desc_param <= mem_rsp_rdata[WORD_W-1:WORD_W-PARAM_W];
                desc_dir   <= mem_rsp_rdata[0];
              end
              default: desc_valid <= mem_rsp_rdata[0];
            endcase
            if (word_k == 2'd3) begin
              state <= ST_CHECK;
            end else begin
              word_k <= word_k + 2'd1;
              state  <= ST_FETCH_REQ;
            end
          end
        end
        ST_CHECK: begin
          offs   <= '0;
          remain <= desc_len;
          if (!desc_valid)          state <= ST_IDLE;
          else if (desc_len == '0)  state <= ST_WB_REQ;
          else if (desc_dir)        state <= ST_RX;
          else                      state <= ST_RD_REQ;
        end
        ST_RD_REQ: if (mem_req_ready) state <= ST_RD_WAIT;
        ST_RD_WAIT: begin
          if (mem_rsp_valid) begin
            hold  <= mem_rsp_rdata;
            state <= ST_TX;
          end
        end
        ST_TX: begin
          if (dev_tx_ready) begin
            offs   <= offs + 1'b1;
            remain <= remain - 1'b1;
            state  <= last_word ? ST_WB_REQ : ST_RD_REQ;
          end
        end
        ST_RX: begin
          if (dev_rx_valid) begin
            hold  <= dev_rx_data;
            state <= ST_WR_REQ;
          end
        end
        ST_WR_REQ: begin
          if (mem_req_ready) begin
            offs   <= offs + 1'b1;
            remain <= remain - 1'b1;
            state  <= last_word ? ST_WB_REQ : ST_RX;
          end
        end
        ST_WB_REQ: begin
          if (mem_req_ready) begin
            word_k <= '0;
            state  <= ST_FETCH_REQ;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dma_ring_engine.sv
module dma_ring_engine
  import dma_ring_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int RING_W = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ADDR_W-1:0]  cfg_base,
  input  logic [RING_W:0]    cfg_count,
  input  logic               cfg_irq_mode,
  input  logic               doorbell,
  output logic [RING_W-1:0]  cur_index,
  output logic               busy,
  output logic               irq,
  output logic               mem_req_valid,
  input  logic               mem_req_ready,
  output logic               mem_req_write,
  output logic [ADDR_W-1:0]  mem_req_addr,
  output logic [31:0]        mem_req_wdata,
  input  logic               mem_rsp_valid,
  input  logic [31:0]        mem_rsp_rdata,
  output logic               dev_tx_valid,
  input  logic               dev_tx_ready,
  output logic [31:0]        dev_tx_data,
  input  logic               dev_rx_valid,
  output logic               dev_rx_ready,
  input  logic [31:0]        dev_rx_data,
  output logic [23:0]        dev_param,
  output logic               dev_dir
);
  logic desc_done;
  logic ring_dry;

  dma_ring_index #(.RING_W(RING_W)) index_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .advance   (desc_done),
    .cfg_count (cfg_count),
    .idx       (cur_index)
  );

  dma_ring_irq irq_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .mode_dry  (cfg_irq_mode),
    .desc_done (desc_done),
    .ring_dry  (ring_dry),
    .irq       (irq)
  );

  dma_ring_ctrl #(.ADDR_W(ADDR_W), .RING_W(RING_W)) ctrl_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .cfg_base      (cfg_base),
    .doorbell      (doorbell),
    .idx           (cur_index),
    .busy          (busy),
    .desc_done     (desc_done),
    .ring_dry      (ring_dry),
    .mem_req_valid (mem_req_valid),
    .mem_req_ready (mem_req_ready),
    .mem_req_write (mem_req_write),
    .mem_req_addr  (mem_req_addr),
    .mem_req_wdata (mem_req_wdata),
    .mem_rsp_valid (mem_rsp_valid),
    .mem_rsp_rdata (mem_rsp_rdata),
    .dev_tx_valid  (dev_tx_valid),
    .dev_tx_ready  (dev_tx_ready),
    .dev_tx_data   (dev_tx_data),
    .dev_rx_valid  (dev_rx_valid),
    .dev_rx_ready  (dev_rx_ready),
    .dev_rx_data   (dev_rx_data),
    .dev_param     (dev_param),
    .dev_dir       (dev_dir)
  );
endmodule

// File: rtl/dma_ring_engine_chk.sv
module dma_ring_engine_chk #(
  parameter int ADDR_W = 16,
  parameter int RING_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic [RING_W:0]   cfg_count,
  input logic [RING_W-1:0] cur_index,
  input logic              busy,
  input logic              irq,
  input logic              cfg_irq_mode,
  input logic              mem_req_valid,
  input logic              mem_req_ready,
  input logic              mem_req_write,
  input logic [ADDR_W-1:0] mem_req_addr,
  input logic [31:0]       mem_req_wdata,
  input logic              dev_tx_valid,
  input logic              dev_tx_ready,
  input logic [31:0]       dev_tx_data,
  input logic              dev_rx_ready
);
  a_r12_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr)
      && $stable(mem_req_write) && $stable(mem_req_wdata));

  a_r3_tx_hold: assert property (@(posedge clk) disable iff (!rst_n)
    dev_tx_valid && !dev_tx_ready |=> dev_tx_valid && $stable(dev_tx_data));

  a_r10_irq_single: assert property (@(posedge clk) disable iff (!rst_n)
    irq && !cfg_irq_mode |=> !irq);

  a_r11_irq_single: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);

  a_r6_index_range: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_count != '0 |-> {1'b0, cur_index} < cfg_count);

  a_r8_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mem_req_valid);

  a_r4_one_stream: assert property (@(posedge clk) disable iff (!rst_n)
    !(dev_tx_valid && dev_rx_ready));
endmodule

bind dma_ring_engine dma_ring_engine_chk #(.ADDR_W(ADDR_W), .RING_W(RING_W)) chk_i (.*);

// File: tb/dma_ring_engine_tb_top.sv
module dma_ring_engine_tb_top;
  localparam int ADDR_W = 16;
  localparam int RING_W = 4;
  localparam int BASE   = 'h40;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic [ADDR_W-1:0] cfg_base = ADDR_W'(BASE);
  logic [RING_W:0]   cfg_count = 5'd4;
  logic              cfg_irq_mode = 1'b0;
  logic              doorbell = 1'b0;
  logic [RING_W-1:0] cur_index;
  logic busy, irq;
  logic mem_req_valid, mem_req_ready, mem_req_write;
  logic [ADDR_W-1:0] mem_req_addr;
  logic [31:0] mem_req_wdata, mem_rsp_rdata, dev_tx_data, dev_rx_data;
  logic mem_rsp_valid, dev_tx_valid, dev_tx_ready, dev_rx_valid, dev_rx_ready;
  logic [23:0] dev_param;
  logic dev_dir;

  dma_ring_engine #(.ADDR_W(ADDR_W), .RING_W(RING_W)) dut_i (.*);

  logic [31:0] mem [0:511];
  logic [31:0] sink [0:63];
  logic [31:0] src  [0:63];
  int sink_n = 0, src_ptr = 0, src_len = 0;
  int req_n = 0, irq_n = 0, cyc = 0;
  int checks = 0, failures = 0;
  logic stall_on = 1'b0;
  logic [23:0] last_param = '0;
  logic last_dir = 1'b0;
  logic arm = 1'b0;
  logic [ADDR_W-1:0] first_addr = '0;

  initial mem_req_ready = 1'b1;
  initial dev_tx_ready = 1'b1;
  initial mem_rsp_valid = 1'b0;
  initial mem_rsp_rdata = '0;
  initial for (int i = 0; i < 512; i++) mem[i] = '0;

  assign dev_rx_valid = (src_ptr < src_len);
  assign dev_rx_data  = src[src_ptr[5:0]];

  always @(posedge clk) begin
    cyc <= cyc + 1;
    mem_rsp_valid <= 1'b0;
    if (mem_req_valid && mem_req_ready) begin
      req_n <= req_n + 1;
      if (arm) begin first_addr <= mem_req_addr; arm <= 1'b0; end
      if (mem_req_write) mem[mem_req_addr[8:0]] <= mem_req_wdata;
      else begin
        mem_rsp_valid <= 1'b1;
        mem_rsp_rdata <= mem[mem_req_addr[8:0]];
      end
    end
    mem_req_ready <= !stall_on || (cyc[1:0] != 2'b00);
    dev_tx_ready  <= !stall_on || cyc[0];
    if (dev_tx_valid && dev_tx_ready) begin
      sink[sink_n[5:0]] <= dev_tx_data;
      sink_n <= sink_n + 1;
      last_param <= dev_param;
      last_dir <= dev_dir;
    end
    if (dev_rx_valid && dev_rx_ready) src_ptr <= src_ptr + 1;
  end

  always @(negedge clk) if (rst_n && irq) irq_n <= irq_n + 1;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic post(input int idx, input int buf_a, input int len, input int ctl);
    mem[BASE + 4*idx]     = buf_a;
    mem[BASE + 4*idx + 1] = len;
    mem[BASE + 4*idx + 2] = ctl;
    mem[BASE + 4*idx + 3] = 32'h1;
  endtask

  task automatic ring_bell_and_wait();
    @(negedge clk) doorbell = 1'b1;
    @(negedge clk) doorbell = 1'b0;
    repeat (3) @(negedge clk);
    while (busy) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R1 busy", busy, 0);
    chk("R1 irq", irq, 0);
    chk("R1 cur_index", cur_index, 0);
    chk("R1 mem_req_valid", mem_req_valid, 0);
  endtask

  task automatic t_mem_to_dev();
    int irq0 = irq_n;
    stall_on = 1'b1;
    for (int i = 0; i < 5; i++) mem['h100 + i] = 32'hA500_0000 + i * 7;
    post(0, 'h100, 5, {24'hABCDE1, 8'h00});
    arm = 1'b1;
    ring_bell_and_wait();
    chk("R2 first fetch addr", first_addr, BASE);
    chk("R3 word count", sink_n, 5);
    for (int i = 0; i < 5; i++) chk("R3 data", sink[i], 32'hA500_0000 + i * 7);
    chk("R2 dev_param", last_param, 24'hABCDE1);
    chk("R2 dev_dir", last_dir, 0);
    chk("R5 flags", mem[BASE + 3], 32'h2);
    chk("R6 index", cur_index, 1);
    chk("R10 irq count", irq_n - irq0, 1);
    stall_on = 1'b0;
  endtask

  task automatic t_dev_to_mem();
    int irq0 = irq_n;
    stall_on = 1'b1;
    for (int i = 0; i < 4; i++) src[i] = 32'h5A00_0010 + i;
    src_ptr = 0;
    src_len = 4;
    post(1, 'h140, 4, {24'h000033, 8'h01});
    ring_bell_and_wait();
    for (int i = 0; i < 4; i++) chk("R4 buffer word", mem['h140 + i], 32'h5A00_0010 + i);
    chk("R4 no overrun", mem['h144], 0);
    chk("R5 flags", mem[BASE + 7], 32'h2);
    chk("R6 index", cur_index, 2);
    chk("R10 irq count", irq_n - irq0, 1);
    stall_on = 1'b0;
  endtask

  task automatic t_zero_len();
    int s0 = sink_n;
    int irq0 = irq_n;
    post(2, 'h180, 0, 0);
    mem['h180] = 32'h1234_5678;
    ring_bell_and_wait();
    chk("R9 flags", mem[BASE + 11], 32'h2);
    chk("R9 no tx", sink_n - s0, 0);
    chk("R9 buffer untouched", mem['h180], 32'h1234_5678);
    chk("R6 index", cur_index, 3);
    chk("R10 irq count", irq_n - irq0, 1);
  endtask

  task automatic t_chain_dry();
    int s0 = sink_n;
    int irq0 = irq_n;
    cfg_irq_mode = 1'b1;
    mem['h1C0] = 32'hC0DE_0001;
    mem['h1C1] = 32'hC0DE_0002;
    post(3, 'h1C0, 2, 0);
    post(0, 'h1C0, 0, 0);
    ring_bell_and_wait();
    chk("R7 first done", mem[BASE + 15], 32'h2);
    chk("R7 second done", mem[BASE + 3], 32'h2);
    chk("R3 chain words", sink_n - s0, 2);
    chk("R6 wrap index", cur_index, 1);
    chk("R11 one irq", irq_n - irq0, 1);
  endtask

  task automatic t_dry_empty();
    int irq0 = irq_n;
    ring_bell_and_wait();
    chk("R11 no irq when nothing done", irq_n - irq0, 0);
    chk("R8 index kept", cur_index, 1);
    cfg_irq_mode = 1'b0;
  endtask

  task automatic t_no_poll();
    int r0;
    post(1, 'h100, 1, 0);
    r0 = req_n;
    repeat (40) @(negedge clk);
    chk("R8 no requests", req_n - r0, 0);
    chk("R8 flags untouched", mem[BASE + 7], 32'h1);
    chk("R8 idle", busy, 0);
    arm = 1'b1;
    ring_bell_and_wait();
    chk("R2 fetch addr idx1", first_addr, BASE + 4);
    chk("R8 processed after doorbell", mem[BASE + 7], 32'h2);
    chk("R6 index", cur_index, 2);
  endtask

  always @(posedge clk) begin
    if (cyc == 150000) begin
      failures++;
      $display("FAIL watchdog R7 actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_mem_to_dev();
    t_dev_to_mem();
    t_zero_len();
    t_chain_dry();
    t_dry_empty();
    t_no_poll();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule